// File: doc/BRIEF.md
# Chained Miss Buffer for a Shared Cache Bank

This block tracks outstanding misses for one bank of a shared last-level cache. A request from the local core cluster either finds an entry that already holds its line and joins that entry's chain, or it takes the lowest-numbered free entry and causes a single fill request for the line. When the fill returns, the chained requests of that entry are retired one per cycle, oldest first. Because of the chain, each line is fetched only once however many local requests wait on it.

An external coherence snoop is presented with a line address and held until the block grants it. The grant is withheld while any entry for that line still has local requests waiting, so the whole local chain is serviced before the snoop proceeds. This holds whether the chain existed before the snoop arrived or was extended after it. The grant may come in the same cycle as the retire of the last chained request.

Top module: `miss_chain_buffer`

## Requirements
- R1: After reset every entry is free, `req_ready` is high, and `fq_valid`, `rt_valid` and `snp_grant` are low.
- R2: An accepted request whose line (address bits above bit 5, for 64-byte lines) matches no entry takes the lowest-index free entry. In the next cycle `fq_valid` is high with `fq_line` set to that line and `fq_tag` set to that entry index.
- R3: An accepted request whose line matches an existing entry is added to that entry's chain and produces no fill request. Addresses that differ only in bits 5..0 count as the same line.
- R4: `req_ready` is low when every entry is in use and the request matches none of them, and also when it matches an entry whose chain already holds CHAIN_DEPTH requests. Otherwise it is high.
- R5: The cycle after `fill_valid` names an entry, that entry's requests appear on `rt_valid`/`rt_id`/`rt_tag`, one per cycle, in the order they were accepted. When several entries are filled, the lowest index is served first.
- R6: A snoop to a line with no entry is granted in the cycle after `snp_valid` rises, and `snp_grant` is high for exactly one cycle.
- R7: A snoop to a line with waiting chained requests is not granted until the last of them retires. The grant is raised in the same cycle as that last retire.
- R8: Requests to the snooped line that are accepted after the snoop arrived are also retired before the grant.
- R9: An entry becomes free in the cycle its last request retires, and it can be allocated again to a new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_id | input | ID_W | Requester tag, returned on retire |
| req_ready | output | 1 | Request can be accepted this cycle |
| fq_valid | output | 1 | Fill request issued for a newly allocated line |
| fq_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the fill request |
| fq_tag | output | log2(ENTRIES) | Entry index the fill must return to |
| fill_valid | input | 1 | Fill data has returned |
| fill_tag | input | log2(ENTRIES) | Entry the fill belongs to |
| snp_valid | input | 1 | External snoop held until granted |
| snp_addr | input | ADDR_W | Byte address of the snoop |
| snp_grant | output | 1 | One-cycle grant for the held snoop |
| rt_valid | output | 1 | A chained request is retired |
| rt_id | output | ID_W | Requester tag of the retired request |
| rt_tag | output | log2(ENTRIES) | Entry the retired request came from |

## Verification
On every cycle the assertions check the following: at most one entry retires per cycle, and only an entry whose fill has arrived may retire. No chain is pushed past its depth. No two live entries ever hold the same line. Each fill request follows a request that missed, and a snoop grant is a single-cycle pulse. The other behaviours can only be shown by the bench scenarios: arrival-order retirement, lowest-index priority between filled entries, and a snoop grant that lands exactly on the last retire of its line, including when the chain grew after the snoop arrived. The same holds for stalling when the entries or a chain are full, and for reuse of a freed entry.

// File: rtl/mb_pkg.sv
package mb_pkg;
  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_WAIT  = 2'd1,
    ENT_READY = 2'd2
  } ent_state_e;
endpackage

// File: rtl/mb_match.sv
// Parallel line compare of one key against every live entry.
module mb_match #(
  parameter int unsigned N  = 32,
  parameter int unsigned LW = 34
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][LW-1:0] lines,
  input  logic [LW-1:0]        key,
  output logic [N-1:0]         hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = valid[i] && (lines[i] == key);
  end
endmodule

// File: rtl/mb_pick.sv
// Lowest-index selector for a request vector.
module mb_pick #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/mb_chain.sv
// One miss entry: state, line and a FIFO of chained requester tags.
module mb_chain
  import mb_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned IDW   = 6,
  parameter int unsigned LW    = 34,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc_i,
  input  logic [LW-1:0]  line_i,
  input  logic           push_i,
  input  logic [IDW-1:0] id_i,
  input  logic           fill_i,
  input  logic           pop_i,
  output ent_state_e     state_o,
  output logic [LW-1:0]  line_o,
  output logic [IDW-1:0] head_o,
  output logic           full_o,
  output logic           last_o
);
  ent_state_e     state_q;
  logic [LW-1:0]  line_q;
  logic [IDW-1:0] mem [DEPTH];
  logic [PW-1:0]  wp_q, rp_q;
  logic [CW-1:0]  cnt_q;
  logic           drained;

  assign drained = pop_i && !push_i && (cnt_q == CW'(1));

  // tag storage: write only, no reset, so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_i) mem[wp_q] <= id_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
      if (pop_i)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENT_FREE;
      line_q  <= '0;
    end else begin
      case (state_q)
        ENT_FREE:  if (alloc_i) begin
                     state_q <= ENT_WAIT;
                     line_q  <= line_i;
                   end
        ENT_WAIT:  if (fill_i) state_q <= ENT_READY;
        ENT_READY: if (drained) state_q <= ENT_FREE;
        default:   state_q <= ENT_FREE;
      endcase
    end
  end

  assign state_o = state_q;
  assign line_o  = line_q;
  assign head_o  = mem[rp_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign last_o  = (cnt_q == CW'(1));

  // R4: the chain is never pushed beyond its depth
  p_no_chain_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o) else $error("chain pushed while full");

  // R5: only an entry whose fill has returned may retire a request
  p_pop_after_fill_r5: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> (state_q == ENT_READY)) else $error("retire before fill");

  // R2: allocation only lands on a free entry
  p_alloc_free_r2: assert property (@(posedge clk) disable iff (rst)
    alloc_i |-> (state_q == ENT_FREE)) else $error("allocation of busy entry");
endmodule

// File: rtl/miss_chain_buffer.sv
module miss_chain_buffer
  import mb_pkg::*;
#(
  parameter int unsigned ENTRIES     = 32,
  parameter int unsigned CHAIN_DEPTH = 4,
  parameter int unsigned ID_W        = 6,
  parameter int unsigned ADDR_W      = 40,
  parameter int unsigned LINE_BYTES  = 64,
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W     = ADDR_W - OFF_W,
  localparam int unsigned TAG_W      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  output logic              req_ready,
  output logic              fq_valid,
  output logic [LINE_W-1:0] fq_line,
  output logic [TAG_W-1:0]  fq_tag,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_grant,
  output logic              rt_valid,
  output logic [ID_W-1:0]   rt_id,
  output logic [TAG_W-1:0]  rt_tag
);
  logic [LINE_W-1:0] req_line, snp_line;
  assign req_line = req_addr[ADDR_W-1:OFF_W];
  assign snp_line = snp_addr[ADDR_W-1:OFF_W];

  ent_state_e                    ent_state [ENTRIES];
  logic [ENTRIES-1:0][LINE_W-1:0] ent_line;
  logic [ID_W-1:0]               ent_head  [ENTRIES];
  logic [ENTRIES-1:0] ent_valid, ent_ready, ent_full, ent_last;
  logic [ENTRIES-1:0] req_hit, snp_hit;
  logic [ENTRIES-1:0] alloc_v, push_v, pop_v, fill_v, freeing_v;

  logic             free_any, rt_any;
  logic [TAG_W-1:0] free_idx, rt_idx;
  logic             req_hit_any, hit_full, req_fire, snp_block;

  mb_match #(.N(ENTRIES), .LW(LINE_W)) u_req_match (
    .valid(ent_valid), .lines(ent_line), .key(req_line), .hit(req_hit));

  mb_match #(.N(ENTRIES), .LW(LINE_W)) u_snp_match (
    .valid(ent_valid), .lines(ent_line), .key(snp_line), .hit(snp_hit));

  mb_pick #(.N(ENTRIES), .IW(TAG_W)) u_free_pick (
    .vec(~ent_valid), .found(free_any), .idx(free_idx));

  mb_pick #(.N(ENTRIES), .IW(TAG_W)) u_rt_pick (
    .vec(ent_ready), .found(rt_any), .idx(rt_idx));

  assign req_hit_any = |req_hit;
  assign hit_full    = |(req_hit & ent_full);
  assign req_ready   = req_hit_any ? !hit_full : free_any;
  assign req_fire    = req_valid && req_ready;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign alloc_v[i]   = req_fire && !req_hit_any && (free_idx == TAG_W'(i));
    assign push_v[i]    = req_fire && (req_hit[i] || alloc_v[i]);
    assign pop_v[i]     = rt_any && (rt_idx == TAG_W'(i));
    assign fill_v[i]    = fill_valid && (fill_tag == TAG_W'(i));
    assign freeing_v[i] = pop_v[i] && ent_last[i] && !push_v[i];
    assign ent_valid[i] = (ent_state[i] != ENT_FREE);
    assign ent_ready[i] = (ent_state[i] == ENT_READY);

    mb_chain #(.DEPTH(CHAIN_DEPTH), .IDW(ID_W), .LW(LINE_W)) u_chain (
      .clk     (clk),
      .rst     (rst),
      .alloc_i (alloc_v[i]),
      .line_i  (req_line),
      .push_i  (push_v[i]),
      .id_i    (req_id),
      .fill_i  (fill_v[i]),
      .pop_i   (pop_v[i]),
      .state_o (ent_state[i]),
      .line_o  (ent_line[i]),
      .head_o  (ent_head[i]),
      .full_o  (ent_full[i]),
      .last_o  (ent_last[i])
    );
  end

  // a snoop waits on any entry of its line that is not emptying this cycle,
  // and on a request to its line being accepted this cycle
  assign snp_block = (|(snp_hit & ~freeing_v)) || (req_fire && (req_line == snp_line));

  always_ff @(posedge clk) begin
    if (rst) begin
      fq_valid  <= 1'b0;
      fq_line   <= '0;
      fq_tag    <= '0;
      rt_valid  <= 1'b0;
      rt_id     <= '0;
      rt_tag    <= '0;
      snp_grant <= 1'b0;
    end else begin
      fq_valid  <= req_fire && !req_hit_any;
      fq_line   <= req_line;
      fq_tag    <= free_idx;
      rt_valid  <= rt_any;
      rt_id     <= ent_head[rt_idx];
      rt_tag    <= rt_idx;
      snp_grant <= snp_valid && !snp_grant && !snp_block;
    end
  end

  // R5: a single retire per cycle
  p_single_retire_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pop_v)) else $error("two entries retired at once");

  // R3: a line lives in at most one entry
  p_unique_line_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_hit)) else $error("line held by two entries");

  // R2: a fill request only follows a request that missed every entry
  p_fill_after_miss_r2: assert property (@(posedge clk) disable iff (rst)
    fq_valid |-> $past(req_valid && !req_hit_any)) else $error("spurious fill request");

  // R6: grant is a single-cycle pulse
  p_grant_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    snp_grant |=> !snp_grant) else $error("grant held two cycles");

  // R5: a retire output needs an entry whose fill had returned
  p_retire_source_r5: assert property (@(posedge clk) disable iff (rst)
    rt_valid |-> $past(|ent_ready)) else $error("retire without filled entry");
endmodule

// File: tb/miss_chain_buffer_bench.sv
module miss_chain_buffer_bench;
  localparam int unsigned ENTRIES = 4;
  localparam int unsigned DEPTH   = 3;
  localparam int unsigned IDW     = 4;
  localparam int unsigned AW      = 16;
  localparam int unsigned LW      = AW - 6;
  localparam int unsigned TW      = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [IDW-1:0] req_id = '0;
  logic          req_ready;
  logic          fq_valid;
  logic [LW-1:0] fq_line;
  logic [TW-1:0] fq_tag;
  logic          fill_valid = 1'b0;
  logic [TW-1:0] fill_tag = '0;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_grant;
  logic          rt_valid;
  logic [IDW-1:0] rt_id;
  logic [TW-1:0] rt_tag;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  miss_chain_buffer #(
    .ENTRIES(ENTRIES), .CHAIN_DEPTH(DEPTH), .ID_W(IDW), .ADDR_W(AW), .LINE_BYTES(64)
  ) u_miss_chain_buffer (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_id(req_id), .req_ready(req_ready),
    .fq_valid(fq_valid), .fq_line(fq_line), .fq_tag(fq_tag),
    .fill_valid(fill_valid), .fill_tag(fill_tag),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_grant(snp_grant),
    .rt_valid(rt_valid), .rt_id(rt_id), .rt_tag(rt_tag)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // present a request; accept it only when ready is expected
  task automatic send(int addr, int id, int exp_ready, string what);
    req_valid = 1'b1;
    req_addr  = AW'(addr);
    req_id    = IDW'(id);
    #1;
    chk(what, int'(req_ready), exp_ready);
    if (exp_ready == 1) tick();
    req_valid = 1'b0;
  endtask

  task automatic fill(int tag);
    fill_valid = 1'b1;
    fill_tag   = TW'(tag);
    tick();
    fill_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 fq_valid", int'(fq_valid), 0);
    chk("R1 rt_valid", int'(rt_valid), 0);
    chk("R1 grant", int'(snp_grant), 0);

    // R2 allocate, R3 chain, R4 chain full, R7 snoop waits for drain
    send('h1000, 1, 1, "R2 first ready");
    chk("R2 fq_valid", int'(fq_valid), 1);
    chk("R2 fq_tag", int'(fq_tag), 0);
    chk("R2 fq_line", int'(fq_line), 'h1000 >> 6);
    send('h1008, 2, 1, "R3 chain ready");
    chk("R3 no fill req", int'(fq_valid), 0);
    send('h103F, 3, 1, "R3 chain ready low bits");
    chk("R3 no fill req 2", int'(fq_valid), 0);
    send('h1010, 4, 0, "R4 chain full stall");
    snp_valid = 1'b1;
    snp_addr  = AW'('h1020);
    tick();
    chk("R7 held 1", int'(snp_grant), 0);
    tick();
    chk("R7 held 2", int'(snp_grant), 0);
    fill(0);
    chk("R5 no retire in fill cycle", int'(rt_valid), 0);
    tick();
    chk("R5 rt 1", int'(rt_id), 1);
    chk("R7 no grant mid chain", int'(snp_grant), 0);
    tick();
    chk("R5 rt 2", int'(rt_id), 2);
    chk("R7 no grant mid chain 2", int'(snp_grant), 0);
    tick();
    chk("R5 rt 3", int'(rt_id), 3);
    chk("R7 grant on last retire", int'(snp_grant), 1);
    snp_valid = 1'b0;
    tick();
    chk("R6 grant pulse", int'(snp_grant), 0);
    chk("R5 chain empty", int'(rt_valid), 0);

    // R9 reuse, R2 lowest free, R4 all entries busy
    send('h2000, 5, 1, "R9 reuse ready");
    chk("R9 reuse tag", int'(fq_tag), 0);
    send('h3000, 6, 1, "R2 second ready");
    chk("R2 tag 1", int'(fq_tag), 1);
    send('h4000, 10, 1, "R2 third ready");
    chk("R2 tag 2", int'(fq_tag), 2);
    send('h5000, 11, 1, "R2 fourth ready");
    chk("R2 tag 3", int'(fq_tag), 3);
    send('h6000, 12, 0, "R4 entries full stall");
    send('h3004, 7, 1, "R4 chain while full");
    chk("R3 no fill while full", int'(fq_valid), 0);

    // R6 snoop to absent line
    snp_valid = 1'b1;
    snp_addr  = AW'('h9000);
    tick();
    chk("R6 immediate grant", int'(snp_grant), 1);
    snp_valid = 1'b0;
    tick();
    chk("R6 single pulse", int'(snp_grant), 0);

    // R8 chain grows after snoop, R5 lowest index first
    snp_valid = 1'b1;
    snp_addr  = AW'('h3000);
    tick();
    chk("R8 held", int'(snp_grant), 0);
    send('h3010, 8, 1, "R8 extend after snoop");
    chk("R8 held after extend", int'(snp_grant), 0);
    fill_valid = 1'b1;
    fill_tag   = TW'(1);
    tick();
    chk("R5 no retire yet", int'(rt_valid), 0);
    fill_tag = TW'(0);
    tick();
    fill_valid = 1'b0;
    chk("R5 rt id6", int'(rt_id), 6);
    chk("R5 rt tag1", int'(rt_tag), 1);
    tick();
    chk("R5 lowest index id5", int'(rt_id), 5);
    chk("R5 lowest index tag0", int'(rt_tag), 0);
    tick();
    chk("R5 rt id7", int'(rt_id), 7);
    chk("R8 no grant before id8", int'(snp_grant), 0);
    tick();
    chk("R8 rt id8", int'(rt_id), 8);
    chk("R8 grant with last", int'(snp_grant), 1);
    snp_valid = 1'b0;
    tick();
    chk("R5 idle while waiting", int'(rt_valid), 0);
    fill(2);
    fill(3);
    chk("R5 rt id10", int'(rt_id), 10);
    tick();
    chk("R5 rt id11", int'(rt_id), 11);
    tick();
    chk("R9 all drained", int'(rt_valid), 0);
    send('h6000, 12, 1, "R9 free after drain");
    chk("R9 realloc tag", int'(fq_tag), 0);
    fill(0);
    tick();
    chk("R9 rt id12", int'(rt_id), 12);
    tick();

    // sweep of chain lengths: order and grant cycle (R3 R5 R7)
    for (int n = 1; n <= DEPTH; n++) begin
      int base;
      base = 'h7000 + n * 'h40;
      for (int k = 0; k < n; k++) begin
        send(base + k * 4, n * 4 + k, 1, "R3 sweep ready");
        chk("R3 sweep fill req", int'(fq_valid), (k == 0) ? 1 : 0);
      end
      snp_valid = 1'b1;
      snp_addr  = AW'(base);
      tick();
      chk("R7 sweep held", int'(snp_grant), 0);
      fill(0);
      for (int k = 0; k < n; k++) begin
        tick();
        chk("R5 sweep order", int'(rt_id), n * 4 + k);
        chk("R7 sweep grant", int'(snp_grant), (k == n - 1) ? 1 : 0);
      end
      snp_valid = 1'b0;
      tick();
      chk("R6 sweep pulse", int'(snp_grant), 0);
      chk("R9 sweep drained", int'(rt_valid), 0);
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule